// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of a 10-bit successive-approximation converter. It drives a trial code to an external DAC and reads the decision of an external analog comparator. Starting at the most significant bit, it decides one result bit per trial. The analog front end, the DAC and the input multiplexer are outside the block. The block sees only a one-bit comparator decision, where 1 means the input is at or above the DAC level.

There are two operations. A conversion resolves all 10 bits. A comparison applies a reference code once and reports whether the input is at or above it. Each operation has a normal-rate and a double-speed timing. Each operation also has a fixed total latency from start to completion. Any cycles not needed by the bit trials become a leading sample phase. Completion is marked by a one-cycle done pulse, which a host can use as an interrupt or DMA request. The result can be read as 10 bits or as an 8-bit view.

Top module: `sar_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `result_o`, `ge_o` and `dac_o` are all zero. Whenever the block is idle, `dac_o` is zero.
- R2: A conversion with `fast_i`=0 raises `done_o` exactly 299 clock edges after the edge that accepted `start_i`. `busy_o` is high for the whole interval.
- R3: A conversion with `fast_i`=1 raises `done_o` exactly 173 clock edges after the accepting edge.
- R4: A conversion tries bit 9 first and bit 0 last. A trial bit is kept when `comp_i`=1, meaning the input is at or above `dac_o`. With an ideal comparator, `result_o` equals the input code.
- R5: `result8_o` is `result_o[9:2]`, truncated without rounding.
- R6: A comparison (`cmp_mode_i`=1) completes in 47 edges at normal rate and 29 edges at double speed. During its decision phase `dac_o` shows the reference code.
- R7: A comparison sets `ge_o` to 1 when the input is at or above the reference and to 0 otherwise, and leaves `result_o` unchanged. A conversion leaves `ge_o` unchanged.
- R8: `start_i` asserted while `busy_o` is high is ignored. The running operation is not restarted and no extra done pulse occurs.
- R9: `done_o` is high for exactly one cycle. `result_o` or `ge_o` updates, and `busy_o` falls, on that same edge.
- R10: Operation, speed and reference code are captured on the accepting edge. Later changes to `cmp_mode_i`, `fast_i` or `ref_i` do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only while idle |
| cmp_mode_i | input | 1 | 1 = comparison, 0 = conversion |
| fast_i | input | 1 | 1 = double-speed timing |
| ref_i | input | 10 | Reference code for comparison |
| comp_i | input | 1 | Comparator decision, 1 = input at or above DAC level |
| dac_o | output | 10 | Code driven to the DAC |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Last conversion result |
| result8_o | output | 8 | Upper 8 bits of the result |
| ge_o | output | 1 | Last comparison outcome |

## Verification
The checks made on every cycle cover the following:
- the exact start-to-done latency for each operation and speed, using a cycle counter that captures the mode at the accepting edge;
- the single-cycle done pulse and the fall of busy on that same edge;
- the rule that result and flag change only at completion;
- the rule that a comparison never disturbs the result;
- the zero DAC code while idle.

Only the bench scenarios can show that a conversion actually reproduces the input code bit by bit, and that the comparison flag matches the input-versus-reference relation. They also show that starts and mode changes issued during a busy operation leave its latency and outcome intact. These scenarios rely on a behavioural comparator in the bench.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_lat_sel.sv
module sar_lat_sel #(
  parameter int RES_W         = 10,
  parameter int NORM_CONV_CYC = 299,
  parameter int FAST_CONV_CYC = 173,
  parameter int NORM_CMP_CYC  = 47,
  parameter int FAST_CMP_CYC  = 29,
  parameter int NORM_SETTLE   = 28,
  parameter int FAST_SETTLE   = 16,
  parameter int TMR_W         = 9
) (
  input  logic             cmp_i,
  input  logic             fast_i,
  output logic [TMR_W-1:0] sample_m1_o,
  output logic [TMR_W-1:0] settle_m1_o
);
  // leftover cycles after the trials form the sample phase
  localparam int NV_S = NORM_CONV_CYC - RES_W * NORM_SETTLE;
  localparam int FV_S = FAST_CONV_CYC - RES_W * FAST_SETTLE;
  localparam int NC_S = NORM_CMP_CYC - NORM_SETTLE;
  localparam int FC_S = FAST_CMP_CYC - FAST_SETTLE;

  localparam logic [TMR_W-1:0] NV_M1 = TMR_W'(NV_S - 1);
  localparam logic [TMR_W-1:0] FV_M1 = TMR_W'(FV_S - 1);
  localparam logic [TMR_W-1:0] NC_M1 = TMR_W'(NC_S - 1);
  localparam logic [TMR_W-1:0] FC_M1 = TMR_W'(FC_S - 1);
  localparam logic [TMR_W-1:0] NS_M1 = TMR_W'(NORM_SETTLE - 1);
  localparam logic [TMR_W-1:0] FS_M1 = TMR_W'(FAST_SETTLE - 1);

  always_comb begin
    unique case ({cmp_i, fast_i})
      2'b00:   sample_m1_o = NV_M1;
      2'b01:   sample_m1_o = FV_M1;
      2'b10:   sample_m1_o = NC_M1;
      default: sample_m1_o = FC_M1;
    endcase
    settle_m1_o = fast_i ? FS_M1 : NS_M1;
  end
endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             keep_i,
  output logic [RES_W-1:0] code_o,
  output logic [RES_W-1:0] next_code_o,
  output logic             last_o
);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] code_q, mask_q;

  // drop or keep the bit on trial, then raise the next lower one
  assign next_code_o = (keep_i ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
  assign last_o      = mask_q[0];
  assign code_o      = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (init_i) begin
      code_q <= MSB;
      mask_q <= MSB;
    end else if (step_i) begin
      code_q <= next_code_o;
      mask_q <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W         = 10,
  parameter int VIEW_W        = 8,
  parameter int NORM_CONV_CYC = 299,
  parameter int FAST_CONV_CYC = 173,
  parameter int NORM_CMP_CYC  = 47,
  parameter int FAST_CMP_CYC  = 29,
  parameter int NORM_SETTLE   = 28,
  parameter int FAST_SETTLE   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_mode_i,
  input  logic              fast_i,
  input  logic [RES_W-1:0]  ref_i,
  input  logic              comp_i,
  output logic [RES_W-1:0]  dac_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  output logic [VIEW_W-1:0] result8_o,
  output logic              ge_o
);
  import sar_pkg::*;

  localparam int TMR_W = $clog2(NORM_CONV_CYC + 1);

  sar_phase_e       phase_q;
  logic             cmp_q, fast_q, done_q, ge_q;
  logic [RES_W-1:0] ref_q, result_q;

  logic             start_ok, sel_cmp, sel_fast;
  logic             tmr_zero, tmr_load, trial_end, fin;
  logic [TMR_W-1:0] sample_m1, settle_m1, tmr_val;
  logic             app_init, app_step, app_last;
  logic [RES_W-1:0] app_code, app_next;

  assign start_ok = start_i && (phase_q == PH_IDLE);
  assign sel_cmp  = start_ok ? cmp_mode_i : cmp_q;
  assign sel_fast = start_ok ? fast_i     : fast_q;

  sar_lat_sel #(
    .RES_W(RES_W), .NORM_CONV_CYC(NORM_CONV_CYC), .FAST_CONV_CYC(FAST_CONV_CYC),
    .NORM_CMP_CYC(NORM_CMP_CYC), .FAST_CMP_CYC(FAST_CMP_CYC),
    .NORM_SETTLE(NORM_SETTLE), .FAST_SETTLE(FAST_SETTLE), .TMR_W(TMR_W)
  ) lat_i (
    .cmp_i(sel_cmp), .fast_i(sel_fast),
    .sample_m1_o(sample_m1), .settle_m1_o(settle_m1)
  );

  assign trial_end = (phase_q == PH_TRIAL) && tmr_zero;
  assign fin       = trial_end && (cmp_q || app_last);
  assign tmr_load  = start_ok
                   || ((phase_q == PH_SAMPLE) && tmr_zero)
                   || (trial_end && !fin);
  assign tmr_val   = start_ok ? sample_m1 : settle_m1;

  sar_timer #(.W(TMR_W)) tmr_i (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  assign app_init = (phase_q == PH_SAMPLE) && tmr_zero && !cmp_q;
  assign app_step = trial_end && !cmp_q;

  sar_approx #(.RES_W(RES_W)) app_i (
    .clk_i, .rst_ni, .init_i(app_init), .step_i(app_step), .keep_i(comp_i),
    .code_o(app_code), .next_code_o(app_next), .last_o(app_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cmp_q    <= 1'b0;
      fast_q   <= 1'b0;
      ref_q    <= '0;
      done_q   <= 1'b0;
      ge_q     <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= fin;
      unique case (phase_q)
        PH_IDLE: if (start_ok) begin
          phase_q <= PH_SAMPLE;
          cmp_q   <= cmp_mode_i;
          fast_q  <= fast_i;
          ref_q   <= ref_i;
        end
        PH_SAMPLE: if (tmr_zero) phase_q <= PH_TRIAL;
        PH_TRIAL: if (fin) begin
          phase_q <= PH_IDLE;
          if (cmp_q) ge_q     <= comp_i;
          else       result_q <= app_next;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign dac_o     = (phase_q != PH_TRIAL) ? '0 : (cmp_q ? ref_q : app_code);
  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;
  assign result_o  = result_q;
  assign result8_o = result_q[RES_W-1 -: VIEW_W];
  assign ge_o      = ge_q;
endmodule

// File: rtl/sar_engine_chk.sv
module sar_engine_chk #(
  parameter int RES_W         = 10,
  parameter int NORM_CONV_CYC = 299,
  parameter int FAST_CONV_CYC = 173,
  parameter int NORM_CMP_CYC  = 47,
  parameter int FAST_CMP_CYC  = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cmp_mode_i,
  input logic             fast_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] dac_o,
  input logic [RES_W-1:0] result_o,
  input logic             ge_o
);
  logic [15:0] run_cnt, exp_lat;
  logic        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= '0;
      exp_lat <= '0;
      mode_q  <= 1'b0;
    end else if (start_i && !busy_o) begin
      run_cnt <= '0;
      mode_q  <= cmp_mode_i;
      exp_lat <= 16'(cmp_mode_i ? (fast_i ? FAST_CMP_CYC : NORM_CMP_CYC)
                                : (fast_i ? FAST_CONV_CYC : NORM_CONV_CYC));
    end else if (busy_o) begin
      run_cnt <= run_cnt + 16'd1;
    end
  end

  // R2 R3 R6 R8
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == exp_lat));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9
  result_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> (done_o && !mode_q));

  // R7
  ge_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ge_o) |-> (done_o && mode_q));

  // R1
  idle_dac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dac_o == '0));
endmodule

bind sar_engine sar_engine_chk #(
  .RES_W(RES_W), .NORM_CONV_CYC(NORM_CONV_CYC), .FAST_CONV_CYC(FAST_CONV_CYC),
  .NORM_CMP_CYC(NORM_CMP_CYC), .FAST_CMP_CYC(FAST_CMP_CYC)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmp_mode_i(cmp_mode_i),
  .fast_i(fast_i), .busy_o(busy_o), .done_o(done_o), .dac_o(dac_o),
  .result_o(result_o), .ge_o(ge_o)
);

// File: tb/sar_engine_tb_top.sv
module sar_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, cmp_mode = 1'b0, fast = 1'b0;
  logic [9:0] ref_c = '0;
  logic       comp;
  logic [9:0] dac, result;
  logic [7:0] result8;
  logic       busy, done, ge;
  int         vin = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  typedef struct {
    bit cmp;
    int val;
    int lat;
    int refv;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  // behavioural comparator: 1 when input is at or above the DAC level
  assign comp = (vin >= int'(dac));

  sar_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_mode_i(cmp_mode),
    .fast_i(fast), .ref_i(ref_c), .comp_i(comp), .dac_o(dac), .busy_o(busy),
    .done_o(done), .result_o(result), .result8_o(result8), .ge_o(ge)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor / scoreboard
  int  busy_cnt = 0;
  int  last_conv = 0;
  int  last_ge = 0;
  bit  prev_done = 0;
  bit  ref_seen = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WDOG", "watchdog expired", cyc, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (busy && exp_q.size() > 0 && exp_q[0].cmp && dac == 10'(exp_q[0].refv))
        ref_seen = 1;
      if (done) begin
        chk(!prev_done, "R9", "done longer than one cycle", 1, 0);
        chk(!busy, "R9", "busy still high with done", int'(busy), 0);
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected done pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.cmp) begin
            chk(busy_cnt == e.lat, "R6", "compare latency", busy_cnt, e.lat);
            chk(int'(ge) == e.val, "R7", "compare flag", int'(ge), e.val);
            chk(int'(result) == last_conv, "R7", "result disturbed by compare",
                int'(result), last_conv);
            chk(ref_seen, "R6", "reference code not on DAC", int'(ref_seen), 1);
            last_ge = e.val;
          end else begin
            chk(busy_cnt == e.lat, (e.lat == 299) ? "R2" : "R3",
                "conversion latency", busy_cnt, e.lat);
            chk(int'(result) == e.val, "R4", "conversion result", int'(result), e.val);
            chk(int'(result8) == (e.val >> 2), "R5", "8-bit view",
                int'(result8), e.val >> 2);
            chk(int'(ge) == last_ge, "R7", "flag disturbed by conversion",
                int'(ge), last_ge);
            last_conv = e.val;
          end
        end
        busy_cnt = 0;
        ref_seen = 0;
      end
      if (busy) busy_cnt++;
      prev_done = done;
    end
  end

  // driver
  task automatic run_op(input bit c, input bit f, input int v, input int r,
                        input bit disturb);
    exp_t e;
    @(negedge clk);
    while (busy || done) @(negedge clk);
    vin = v;
    ref_c = 10'(r);
    cmp_mode = c;
    fast = f;
    e.cmp = c;
    e.refv = r;
    e.val = c ? int'(v >= r) : v;
    e.lat = c ? (f ? 29 : 47) : (f ? 173 : 299);
    exp_q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R8 R10: restart attempt and input changes mid-operation
      repeat (20) @(negedge clk);
      cmp_mode = ~c;
      fast = ~f;
      ref_c = ~10'(r);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy after reset", int'(busy), 0);
    chk(!done, "R1", "done after reset", int'(done), 0);
    chk(result == 0, "R1", "result after reset", int'(result), 0);
    chk(!ge, "R1", "flag after reset", int'(ge), 0);
    chk(dac == 0, "R1", "dac after reset", int'(dac), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dac == 0 && !busy, "R1", "idle dac", int'(dac), 0);

    // R2 R4 R5 normal conversions
    run_op(0, 0, 0,    0, 0);
    run_op(0, 0, 1023, 0, 0);
    run_op(0, 0, 512,  0, 0);
    run_op(0, 0, 341,  0, 0);
    run_op(0, 0, 682,  0, 0);
    run_op(0, 0, 1,    0, 0);
    // R3 fast conversions
    run_op(0, 1, 1023, 0, 0);
    run_op(0, 1, 0,    0, 0);
    run_op(0, 1, 777,  0, 0);
    run_op(0, 1, 3,    0, 0);
    // R6 R7 comparisons, both speeds, equal and off-by-one
    run_op(1, 0, 500,  500, 0);
    run_op(1, 0, 499,  500, 0);
    run_op(0, 1, 258,  0, 0);
    run_op(1, 0, 1023, 0, 0);
    run_op(1, 1, 0,    1, 0);
    run_op(1, 1, 1000, 999, 0);
    run_op(1, 1, 200,  201, 0);
    // R8 R10 disturbed operations
    run_op(0, 0, 300,  0, 1);
    run_op(0, 1, 901,  0, 1);
    run_op(1, 0, 600,  400, 1);
    run_op(1, 1, 100,  700, 1);
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0 && !busy, "R8", "idle after disturbed runs",
        int'(busy), 0);
    chk(dac == 0, "R1", "idle dac at end", int'(dac), 0);
    finish_run();
  end
endmodule